// File: doc/BRIEF.md
# Host-Driven Memory Cycle Controller

This block lets a host processor run one memory read or write at a time through a small register file. It uses the same four-phase request/acknowledge handshake that the bulk transfer engine uses. The host loads the byte registers, then writes the control register with the request bit set. The block then drives the memory request, waits for the active-low acknowledge to fall and return, and reports the end of the cycle through a status bit. For a read, the returned bytes are left in the data registers.

In 8-bit mode only the low lane is used. In 16-bit mode a second byte register feeds and captures the high lane. Two host-selected lane-valid bits choose which lanes are driven or captured, and they are shown on two active-low lane strobes. The block refuses a request while the bulk engine reports activity and records the refusal in a sticky error flag. The acknowledge input is asynchronous and passes through a synchronizer first.

Register map (2-bit address): 0 = low data byte, 1 = high data byte, 2 = control (bit 7 request, bit 6 write=1/read=0, bit 4 16-bit mode, bit 1 high-lane valid, bit 0 low-lane valid), 3 = status (bit 7 cycle complete, bit 0 refused-request error). Reads are combinational from `reg_addr`.

Top module: `hostmem_cycle_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `mem_req` is 0, `mem_write` is 0 and both lane strobes are 1.
- R2: An accepted request raises `mem_req`. `mem_req` stays high until the acknowledge is seen low, and the cycle does not complete until the acknowledge has returned high.
- R3: At the end of a cycle, status bit 7 reads 1, control bit 7 reads 0 and `mem_req` stays low.
- R4: During a write cycle `mem_write` is 1 and `mem_dout` equals {high byte register, low byte register}. During a read cycle `mem_write` is 0.
- R5: An 8-bit read captures `mem_din[7:0]` into the low byte register and leaves the high byte register unchanged.
- R6: A 16-bit read captures `mem_din[7:0]` only when the low-valid bit is set and `mem_din[15:8]` only when the high-valid bit is set.
- R7: The lane strobes are active low. During an 8-bit cycle the low strobe is 0 and the high strobe is 1. During a 16-bit cycle each strobe is the inverse of its valid bit. Outside a cycle both strobes are 1.
- R8: A control write with bit 7 set while `dma_busy` is 1 starts no cycle, leaves control bit 7 at 0 and sets status bit 0. That bit holds until the host writes status with bit 0 set.
- R9: Accepting a new request clears status bit 7.
- R10: While a cycle is running, host writes to the data and control registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` |
| dma_busy | input | 1 | Bulk transfer engine is active |
| mem_req | output | 1 | Handshake request |
| mem_ack_n | input | 1 | Asynchronous active-low acknowledge |
| mem_write | output | 1 | 1 when the current cycle is a write |
| mem_dout | output | 16 | Write data {high lane, low lane} |
| mem_din | input | 16 | Read data {high lane, low lane} |
| lane_hi_n | output | 1 | High-lane valid strobe, active low |
| lane_lo_n | output | 1 | Low-lane valid strobe, active low |

## Verification
Two events can land in the same clock cycle: `dma_busy` rising, and the host's request write. The bench raises `dma_busy` on the same edge that the control write is presented. It then checks that no request ever appears on the memory side, that control bit 7 stays 0 and that the error flag is set. It also places host writes in the middle of a running cycle, and judges from the memory-side data and the register reads that the writes were dropped and did not corrupt the cycle.

// File: rtl/hmc_pkg.sv
// Shared definitions for the host memory cycle controller.
// Assumes a 2-bit register address space and byte-wide registers.
package hmc_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DLO  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DHI  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int unsigned B_REQ   = 7;
    localparam int unsigned B_WRITE = 6;
    localparam int unsigned B_WIDE  = 4;
    localparam int unsigned B_HV    = 1;
    localparam int unsigned B_LV    = 0;
    localparam int unsigned B_DONE  = 7;
    localparam int unsigned B_ERR   = 0;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_ASK  = 2'd1,
        HS_DROP = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hmc_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 1; every stage resets to RST_VAL.
module hmc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the level one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[i] <= RST_VAL;
                else if (i == 0) chain[i] <= d_async;
                else             chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hmc_handshake.sv
// Four-phase request/acknowledge sequencer for a single memory cycle.
// Assumes ack_s is already synchronized and active low. go is held high
// for the whole cycle and drops on the same edge that done is taken.
module hmc_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ack_s,
    output logic req,
    output logic capture,
    output logic done
);
    import hmc_pkg::*;

    hs_state_e state_q, state_d;

    // Next-state selection for the handshake phases.
    always_comb begin
        state_d = state_q;
        case (state_q)
            HS_IDLE: if (go)     state_d = HS_ASK;
            HS_ASK:  if (!ack_s) state_d = HS_DROP;
            HS_DROP: if (ack_s)  state_d = HS_IDLE;
            default:             state_d = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    assign req     = (state_q == HS_ASK);
    assign capture = (state_q == HS_ASK) && !ack_s;
    assign done    = (state_q == HS_DROP) && ack_s;

    // R2: request is held until the acknowledge is seen low
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack_s |=> req);
    // R2: request only falls after a low acknowledge
    p_req_fall_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(!ack_s));
    // R3: no new request directly after completion
    p_no_req_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !req);
endmodule

// File: rtl/hmc_regs.sv
// Host register file: data bytes, control and status.
// Assumes capture and done come from the handshake sequencer and that a
// cycle is running exactly while the request bit is set.
module hmc_regs (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [hmc_pkg::ADDR_W-1:0] addr,
    input  logic [hmc_pkg::BYTE_W-1:0] wdata,
    output logic [hmc_pkg::BYTE_W-1:0] rdata,
    input  logic                      dma_busy,
    input  logic                      capture,
    input  logic                      done,
    input  logic [2*hmc_pkg::BYTE_W-1:0] din,
    output logic [hmc_pkg::BYTE_W-1:0] data_lo,
    output logic [hmc_pkg::BYTE_W-1:0] data_hi,
    output logic                      req_q,
    output logic                      write_q,
    output logic                      wide_q,
    output logic                      hv_q,
    output logic                      lv_q
);
    import hmc_pkg::*;

    logic done_q, err_q;
    logic ctrl_wr, stat_wr, ask, accept, refuse;
    logic cap_lo, cap_hi;
    logic unused_bits;

    assign ctrl_wr = wr_en && (addr == A_CTRL) && !req_q;
    assign stat_wr = wr_en && (addr == A_STAT);
    assign ask     = ctrl_wr && wdata[B_REQ];
    assign accept  = ask && !dma_busy;
    assign refuse  = ask && dma_busy;
    assign cap_lo  = capture && !write_q && (!wide_q || lv_q);
    assign cap_hi  = capture && !write_q && wide_q && hv_q;
    assign unused_bits = ^{wdata[5], wdata[3:2]};

    // Low data byte: host load when idle, memory capture on reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 data_lo <= '0;
        else if (cap_lo)                            data_lo <= din[BYTE_W-1:0];
        else if (wr_en && addr == A_DLO && !req_q)  data_lo <= wdata;
    end

    // High data byte: host load when idle, high-lane capture on 16-bit reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 data_hi <= '0;
        else if (cap_hi)                            data_hi <= din[2*BYTE_W-1:BYTE_W];
        else if (wr_en && addr == A_DHI && !req_q)  data_hi <= wdata;
    end

    // Control fields: updated by idle host writes, except for refused requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            wide_q  <= 1'b0;
            hv_q    <= 1'b0;
            lv_q    <= 1'b0;
        end else if (ctrl_wr && !refuse) begin
            write_q <= wdata[B_WRITE];
            wide_q  <= wdata[B_WIDE];
            hv_q    <= wdata[B_HV];
            lv_q    <= wdata[B_LV];
        end
    end

    // Request bit: set on acceptance, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= 1'b0;
        else if (accept) req_q <= 1'b1;
        else if (done)   req_q <= 1'b0;
    end

    // Status: complete bit and sticky refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (accept)     done_q <= 1'b0;
            else if (done)  done_q <= 1'b1;
            if (refuse)                      err_q <= 1'b1;
            else if (stat_wr && wdata[B_ERR]) err_q <= 1'b0;
        end
    end

    // Host read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_DLO:  rdata = data_lo;
            A_DHI:  rdata = data_hi;
            A_CTRL: begin
                rdata[B_REQ]   = req_q;
                rdata[B_WRITE] = write_q;
                rdata[B_WIDE]  = wide_q;
                rdata[B_HV]    = hv_q;
                rdata[B_LV]    = lv_q;
            end
            default: begin
                rdata[B_DONE] = done_q;
                rdata[B_ERR]  = err_q;
            end
        endcase
    end

    // R8: a request written while DMA is active never starts a cycle
    p_dma_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_CTRL && wdata[B_REQ] && dma_busy && !req_q |=> !req_q && err_q);
    // R8: error flag is sticky until cleared by the host
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !(stat_wr && wdata[B_ERR]) |=> err_q);
    // R3: completion reports and drops the request
    p_done_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done_q && !req_q);
    // R10: write-cycle data stays put for the whole cycle
    p_busy_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && write_q && $past(req_q) |-> $stable(data_lo) && $stable(data_hi));
    // R9: acceptance clears the complete bit
    p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> !done_q);
endmodule

// File: rtl/hostmem_cycle_ctrl.sv
// Top level: lets a host run single memory reads or writes using a
// four-phase request/acknowledge handshake, in 8-bit or 16-bit mode.
// Assumes mem_din is stable while the acknowledge is low.
module hostmem_cycle_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dma_busy,
    output logic        mem_req,
    input  logic        mem_ack_n,
    output logic        mem_write,
    output logic [15:0] mem_dout,
    input  logic [15:0] mem_din,
    output logic        lane_hi_n,
    output logic        lane_lo_n
);
    import hmc_pkg::*;

    logic ack_s, capture, done;
    logic req_q, write_q, wide_q, hv_q, lv_q;
    logic [BYTE_W-1:0] data_lo, data_hi;

    hmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d_async(mem_ack_n), .q_sync(ack_s)
    );

    hmc_handshake u_hs (
        .clk(clk), .rst_n(rst_n), .go(req_q), .ack_s(ack_s),
        .req(mem_req), .capture(capture), .done(done)
    );

    hmc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .dma_busy(dma_busy),
        .capture(capture), .done(done), .din(mem_din),
        .data_lo(data_lo), .data_hi(data_hi), .req_q(req_q),
        .write_q(write_q), .wide_q(wide_q), .hv_q(hv_q), .lv_q(lv_q)
    );

    assign mem_write = req_q && write_q;
    assign mem_dout  = {data_hi, data_lo};

    // Lane strobes: idle high, fixed low lane in 8-bit mode, host-chosen in 16-bit mode.
    always_comb begin
        if (!req_q)      {lane_hi_n, lane_lo_n} = 2'b11;
        else if (wide_q) {lane_hi_n, lane_lo_n} = {~hv_q, ~lv_q};
        else             {lane_hi_n, lane_lo_n} = 2'b10;
    end

    // R7: a request on the bus always comes with a cycle in progress
    p_req_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> req_q);
    // R4: write direction never changes while the request is out
    p_dir_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> $stable(mem_write));
endmodule

// File: tb/hostmem_cycle_ctrl_test.sv
module hostmem_cycle_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        dma_busy = 1'b0;
    logic        mem_req;
    logic        mem_ack_n = 1'b1;
    logic        mem_write;
    logic [15:0] mem_dout;
    logic [15:0] mem_din = 16'd0;
    logic        lane_hi_n, lane_lo_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hostmem_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_busy(dma_busy),
        .mem_req(mem_req), .mem_ack_n(mem_ack_n), .mem_write(mem_write),
        .mem_dout(mem_dout), .mem_din(mem_din),
        .lane_hi_n(lane_hi_n), .lane_lo_n(lane_lo_n)
    );

    // ctrl, lo, hi, din, exp dout, exp lanes {hi_n,lo_n}, exp lo, exp hi
    localparam logic [73:0] VEC [7] = '{
        {8'hC0, 8'hA5, 8'h3C, 16'h0000, 16'h3CA5, 2'b10, 8'hA5, 8'h3C},
        {8'h80, 8'h11, 8'h22, 16'hBEEF, 16'h2211, 2'b10, 8'hEF, 8'h22},
        {8'hD3, 8'h12, 8'h34, 16'h0000, 16'h3412, 2'b00, 8'h12, 8'h34},
        {8'h93, 8'h00, 8'h00, 16'hCAFE, 16'h0000, 2'b00, 8'hFE, 8'hCA},
        {8'h92, 8'h55, 8'h66, 16'h7788, 16'h6655, 2'b01, 8'h55, 8'h77},
        {8'h91, 8'h55, 8'h66, 16'h7788, 16'h6655, 2'b10, 8'h88, 8'h66},
        {8'hD2, 8'h9A, 8'hBC, 16'h0000, 16'hBC9A, 2'b01, 8'h9A, 8'hBC}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_req(input logic lvl);
        for (int i = 0; i < 40 && mem_req !== lvl; i++) @(negedge clk);
    endtask

    task automatic run_vec(input logic [73:0] v);
        logic [7:0] r;
        wr_reg(2'd0, v[65:58]);
        wr_reg(2'd1, v[57:50]);
        wr_reg(2'd2, v[73:66]);
        rd_reg(2'd3, r);
        check("R9 complete cleared on accept", {8'd0, r}, 16'h0000);
        wait_req(1'b1);
        repeat (4) @(negedge clk);
        check("R2 req held without ack", {15'd0, mem_req}, 16'd1);
        check("R7 lane strobes in cycle", {14'd0, lane_hi_n, lane_lo_n}, {14'd0, v[17:16]});
        check("R4 direction", {15'd0, mem_write}, {15'd0, v[72]});
        if (v[72]) check("R4 write data", mem_dout, v[33:18]);
        mem_din = v[49:34];
        mem_ack_n = 1'b0;
        wait_req(1'b0);
        repeat (3) @(negedge clk);
        rd_reg(2'd3, r);
        check("R2 no completion while ack low", {8'd0, r}, 16'h0000);
        mem_ack_n = 1'b1;
        repeat (6) @(negedge clk);
        rd_reg(2'd3, r);
        check("R3 complete bit", {8'd0, r}, 16'h0080);
        rd_reg(2'd2, r);
        check("R3 request bit cleared", {15'd0, r[7]}, 16'd0);
        check("R3 req stays low", {15'd0, mem_req}, 16'd0);
        check("R7 strobes idle", {14'd0, lane_hi_n, lane_lo_n}, 16'd3);
        rd_reg(2'd0, r);
        check(v[72] ? "R4 low byte kept" : (v[70] ? "R6 low capture" : "R5 low capture"), {8'd0, r}, {8'd0, v[15:8]});
        rd_reg(2'd1, r);
        check(v[70] ? "R6 high capture" : "R5 high untouched", {8'd0, r}, {8'd0, v[7:0]});
    endtask

    initial begin
        for (int i = 0; i < 200000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], r);
            check("R1 register reset", {8'd0, r}, 16'h0000);
        end
        check("R1 idle outputs", {13'd0, mem_req, mem_write, lane_hi_n & lane_lo_n}, 16'd1);

        for (int k = 0; k < 7; k++) run_vec(VEC[k]);

        // R8: DMA rises on the same edge as the request write
        @(negedge clk);
        dma_busy = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'hC0;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 no request during DMA", {15'd0, mem_req}, 16'd0);
        rd_reg(2'd2, r);
        check("R8 request bit stays 0", {15'd0, r[7]}, 16'd0);
        rd_reg(2'd3, r);
        check("R8 error set", {15'd0, r[0]}, 16'd1);
        dma_busy = 1'b0;
        repeat (3) @(negedge clk);
        rd_reg(2'd3, r);
        check("R8 error sticky", {15'd0, r[0]}, 16'd1);
        wr_reg(2'd3, 8'h01);
        rd_reg(2'd3, r);
        check("R8 error cleared", {15'd0, r[0]}, 16'd0);

        // R10: host writes during a running write cycle are dropped
        wr_reg(2'd0, 8'h5A);
        wr_reg(2'd1, 8'hC3);
        wr_reg(2'd2, 8'hC0);
        wait_req(1'b1);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd2, 8'h13);
        check("R10 data unchanged on bus", mem_dout, 16'hC35A);
        rd_reg(2'd2, r);
        check("R10 control unchanged", {8'd0, r}, 16'h00C0);
        mem_ack_n = 1'b0;
        wait_req(1'b0);
        mem_ack_n = 1'b1;
        repeat (6) @(negedge clk);
        rd_reg(2'd3, r);
        check("R3 complete after R10 cycle", {8'd0, r}, 16'h0080);
        rd_reg(2'd0, r);
        check("R10 low byte kept", {8'd0, r}, 16'h005A);

        // R5: 8-bit read ignores high-valid bits and high lane
        wr_reg(2'd1, 8'h44);
        wr_reg(2'd2, 8'h82);
        wait_req(1'b1);
        check("R7 8-bit strobes ignore valid bits", {14'd0, lane_hi_n, lane_lo_n}, 16'd2);
        mem_din = 16'h9911;
        mem_ack_n = 1'b0;
        wait_req(1'b0);
        mem_ack_n = 1'b1;
        repeat (6) @(negedge clk);
        rd_reg(2'd1, r);
        check("R5 high byte untouched", {8'd0, r}, 16'h0044);
        rd_reg(2'd0, r);
        check("R5 low byte captured", {8'd0, r}, 16'h0011);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule